// File: doc/BRIEF.md
# Grouped Interrupt Aggregator with Priority Readout

This block gathers a bank of asynchronous interrupt inputs, arranged in groups of 32, and drives a single fast-interrupt line (`fiq_o`). Each input first passes through a synchronizer. It is then latched into a per-group status register. A per-source type bit chooses how the input is latched. A pulse source sets its status bit on a rising edge. A level source sets its status bit whenever the input is high. Latched bits stay set until software writes a 1 to them. A per-source enable selects which latched bits take part in the fast-interrupt path.

Software reaches the block through a 32-bit register port. The port has a write strobe, a read strobe and read data that returns one cycle after the read strobe. Software can do all of the prioritization itself, using a readout of the highest-priority pending source, a per-group pending summary and the status registers.

Software can also let the hardware mask interrupts. It does this by reading the vector register. That read returns the winning source and arms a priority mask at that source. While the mask is armed, only sources with a strictly lower number can raise `fiq_o`. Clearing the status bit of the masked source releases the mask.

Source numbering: group M, bit b is source M*32+b, and it is driven on `irq_in[M*32+b]`. A lower source number always has higher priority.

Top module: `fiq_group_agg`

## Requirements
- R1: After reset, all status, enable and type bits are 0, the mask is disarmed, `fiq_o` is low and every register reads 0.
- R2: A source whose type bit is 0 (pulse) sets its status bit on a rising edge of its input. The bit is set within 3 clock edges of the input change and stays set after the input falls.
- R3: A source whose type bit is 1 (level) has its status bit set while its input is high. If the status bit is cleared while the input is still high, the bit stays set.
- R4: Each group M has two write-1-to-clear registers, at 0x400+M*0x20+0x04 and at 0x400+M*0x20+0x14. Writing 1 to a bit clears that status bit and writing 0 leaves it unchanged. After a pulse source is cleared, its next rising edge is captured again.
- R5: The enable register at 0x200+M*0x20+0x00 holds one bit per source. Register +0x04 reads the raw status. Register +0x14 reads status AND enable.
- R6: Register 0x00C reads 1 plus the number of the lowest-numbered pending enabled source, or 0 when none is pending. This readout ignores the mask.
- R7: Register 0x014 has bit M set when group M has any pending enabled source. Its bits above the group count read 0.
- R8: `fiq_o` is high exactly when some pending enabled source is not masked. Without any vector read, no source is ever masked.
- R9: Reading register 0x01C returns 1 plus the number of the lowest-numbered pending, enabled, unmasked source, or 0 when there is none. When it finds a source, the read arms the mask at that source number, and that source and all higher-numbered sources are then masked.
- R10: Writing 1 to the masked source's bit in either clear register disarms the mask.
- R11: Read data appears in the cycle after the read strobe and is 0 in other cycles. The enable register and the type register (0x200+M*0x20+0x1C) read back their contents. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_GROUPS*32 | Asynchronous interrupt inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after reg_rd |
| fiq_o | output | 1 | Fast-interrupt request |

## Verification
A wrong status bit, for example a missed pulse edge or a level bit that fails to re-latch, shows on `fiq_o` and in the priority readout one cycle after the faulty latch. That is at most three edges after the input changes. A mask that is armed or released at the wrong time shows at once, as `fiq_o` being held low or raised in the wrong cycle. A stale mask number shows as a wrong value on the next vector read. Decode errors show on the read port one cycle after the strobe, or as a status bit that survives or loses a write that should not have touched it.

// File: rtl/fga_pkg.sv
package fga_pkg;
    localparam int GROUP_W = 32;

    // Global register offsets
    localparam logic [11:0] PRIO_ADDR = 12'h00C;
    localparam logic [11:0] GRP_ADDR  = 12'h014;
    localparam logic [11:0] VEC_ADDR  = 12'h01C;

    // Per-group bases and offsets
    localparam int CFG_BASE  = 32'h200;
    localparam int STAT_BASE = 32'h400;
    localparam int GRP_STEP  = 32'h20;
    localparam int EN_OFS    = 32'h00;
    localparam int TYPE_OFS  = 32'h1C;
    localparam int RAW_OFS   = 32'h04;
    localparam int FEN_OFS   = 32'h14;

    typedef struct packed {
        logic [GROUP_W-1:0] status;
        logic [GROUP_W-1:0] prev;
        logic [GROUP_W-1:0] en;
        logic [GROUP_W-1:0] lvl;
    } grp_state_t;
endpackage

// File: rtl/fga_sync.sv
module fga_sync #(
    parameter int W      = 64,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/fga_prio.sv
module fga_prio #(
    parameter int N  = 64,
    parameter int IW = 6
) (
    input  logic [N-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    // Lowest index wins: scan downwards so the last hit is the lowest
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/fga_group.sv
module fga_group
    import fga_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [GROUP_W-1:0] src_i,
    input  logic               en_wr_i,
    input  logic               lvl_wr_i,
    input  logic [GROUP_W-1:0] wdata_i,
    input  logic [GROUP_W-1:0] clr_i,
    output logic [GROUP_W-1:0] status_o,
    output logic [GROUP_W-1:0] en_o,
    output logic [GROUP_W-1:0] lvl_o
);
    grp_state_t st_d, st_q;
    logic [GROUP_W-1:0] rise;
    logic [GROUP_W-1:0] set;

    always_comb begin
        st_d      = st_q;
        rise      = src_i & ~st_q.prev;
        set       = (st_q.lvl & src_i) | (~st_q.lvl & rise);
        st_d.prev = src_i;
        // a new event in the same cycle as a clear takes precedence
        st_d.status = (st_q.status & ~clr_i) | set;
        if (en_wr_i)  st_d.en  = wdata_i;
        if (lvl_wr_i) st_d.lvl = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;
    assign en_o     = st_q.en;
    assign lvl_o    = st_q.lvl;
endmodule

// File: rtl/fiq_group_agg.sv
module fiq_group_agg
    import fga_pkg::*;
#(
    parameter int NUM_GROUPS  = 2,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_GROUPS*GROUP_W-1:0] irq_in,
    input  logic                          reg_wr,
    input  logic                          reg_rd,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [31:0]                   reg_wdata,
    output logic [31:0]                   reg_rdata,
    output logic                          fiq_o
);
    localparam int NUM_SRC = NUM_GROUPS * GROUP_W;
    localparam int SRC_W   = $clog2(NUM_SRC);

    typedef struct packed {
        logic             armed;
        logic [SRC_W-1:0] mask_idx;
        logic [31:0]      rdata;
    } top_state_t;

    top_state_t s_d, s_q;

    logic [NUM_SRC-1:0]    sync_all;
    logic [NUM_SRC-1:0]    status_all;
    logic [NUM_SRC-1:0]    en_all;
    logic [NUM_SRC-1:0]    type_all;
    logic [NUM_SRC-1:0]    clr_all;
    logic [NUM_SRC-1:0]    pend_all;
    logic [NUM_SRC-1:0]    vis_all;
    logic [NUM_GROUPS-1:0] grp_pend;
    logic                  mask_armed;
    logic                  prio_found, vec_found;
    logic [SRC_W-1:0]      prio_idx, vec_idx;
    logic [31:0]           rd_val;

    fga_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (irq_in),
        .q_o   (sync_all)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic en_wr, lvl_wr, clr_hit;
        assign en_wr   = reg_wr && (reg_addr == ADDR_W'(CFG_BASE + g*GRP_STEP + EN_OFS));
        assign lvl_wr  = reg_wr && (reg_addr == ADDR_W'(CFG_BASE + g*GRP_STEP + TYPE_OFS));
        assign clr_hit = reg_wr && ((reg_addr == ADDR_W'(STAT_BASE + g*GRP_STEP + RAW_OFS)) ||
                                    (reg_addr == ADDR_W'(STAT_BASE + g*GRP_STEP + FEN_OFS)));
        assign clr_all[g*GROUP_W +: GROUP_W] = clr_hit ? reg_wdata : '0;

        fga_group grp_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_i    (sync_all[g*GROUP_W +: GROUP_W]),
            .en_wr_i  (en_wr),
            .lvl_wr_i (lvl_wr),
            .wdata_i  (reg_wdata),
            .clr_i    (clr_all[g*GROUP_W +: GROUP_W]),
            .status_o (status_all[g*GROUP_W +: GROUP_W]),
            .en_o     (en_all[g*GROUP_W +: GROUP_W]),
            .lvl_o    (type_all[g*GROUP_W +: GROUP_W])
        );

        assign grp_pend[g] = |pend_all[g*GROUP_W +: GROUP_W];
    end

    assign pend_all   = status_all & en_all;
    assign mask_armed = s_q.armed;

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            vis_all[i] = !s_q.armed || (SRC_W'(i) < s_q.mask_idx);
        end
    end

    fga_prio #(.N(NUM_SRC), .IW(SRC_W)) prio_i (
        .vec_i   (pend_all),
        .found_o (prio_found),
        .idx_o   (prio_idx)
    );

    fga_prio #(.N(NUM_SRC), .IW(SRC_W)) vec_i (
        .vec_i   (pend_all & vis_all),
        .found_o (vec_found),
        .idx_o   (vec_idx)
    );

    // Read decode
    always_comb begin
        rd_val = '0;
        if (reg_addr == ADDR_W'(PRIO_ADDR)) begin
            rd_val = prio_found ? 32'(prio_idx) + 32'd1 : 32'd0;
        end else if (reg_addr == ADDR_W'(GRP_ADDR)) begin
            rd_val = 32'(grp_pend);
        end else if (reg_addr == ADDR_W'(VEC_ADDR)) begin
            rd_val = vec_found ? 32'(vec_idx) + 32'd1 : 32'd0;
        end
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (reg_addr == ADDR_W'(CFG_BASE + g*GRP_STEP + EN_OFS))
                rd_val = en_all[g*GROUP_W +: GROUP_W];
            if (reg_addr == ADDR_W'(CFG_BASE + g*GRP_STEP + TYPE_OFS))
                rd_val = type_all[g*GROUP_W +: GROUP_W];
            if (reg_addr == ADDR_W'(STAT_BASE + g*GRP_STEP + RAW_OFS))
                rd_val = status_all[g*GROUP_W +: GROUP_W];
            if (reg_addr == ADDR_W'(STAT_BASE + g*GRP_STEP + FEN_OFS))
                rd_val = pend_all[g*GROUP_W +: GROUP_W];
        end
    end

    // Next state: read return, mask release, mask arming
    always_comb begin
        s_d       = s_q;
        s_d.rdata = reg_rd ? rd_val : '0;
        if (s_q.armed && clr_all[s_q.mask_idx]) begin
            s_d.armed = 1'b0;
        end
        if (reg_rd && (reg_addr == ADDR_W'(VEC_ADDR)) && vec_found) begin
            s_d.armed    = 1'b1;
            s_d.mask_idx = vec_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign reg_rdata = s_q.rdata;
    assign fiq_o     = |(pend_all & vis_all);
endmodule

// File: rtl/fga_chk.sv
module fga_chk
    import fga_pkg::*;
#(
    parameter int NUM_SRC    = 64,
    parameter int NUM_GROUPS = 2,
    parameter int ADDR_W     = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_rd,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [31:0]        reg_rdata,
    input logic [NUM_SRC-1:0] status_all,
    input logic [NUM_SRC-1:0] clr_all,
    input logic [NUM_SRC-1:0] sync_all,
    input logic [NUM_SRC-1:0] type_all,
    input logic               mask_armed
);
    // R4
    w1c_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(status_all) & ~$past(clr_all)) & ~status_all) == '0));

    // R3
    lvl_relatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(sync_all) & $past(type_all)) & ~status_all) == '0));

    // R9
    arm_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mask_armed) |-> ($past(reg_rd) && ($past(reg_addr) == ADDR_W'(VEC_ADDR))));

    // R7
    grp_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (reg_addr == ADDR_W'(GRP_ADDR))) |=> ((reg_rdata >> NUM_GROUPS) == '0));

    // R6
    prio_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (reg_addr == ADDR_W'(PRIO_ADDR))) |=> (reg_rdata <= 32'(NUM_SRC)));

    // R11
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> (reg_rdata == '0));
endmodule

bind fiq_group_agg fga_chk #(
    .NUM_SRC    (NUM_SRC),
    .NUM_GROUPS (NUM_GROUPS),
    .ADDR_W     (ADDR_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .status_all (status_all),
    .clr_all    (clr_all),
    .sync_all   (sync_all),
    .type_all   (type_all),
    .mask_armed (mask_armed)
);

// File: tb/fiq_group_agg_tb_top.sv
`timescale 1ns/1ps
module fiq_group_agg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_in = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fiq_o;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fiq_group_agg dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .fiq_o     (fiq_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse(input int s);
        @(negedge clk);
        irq_in[s] = 1'b1;
        @(negedge clk);
        irq_in[s] = 1'b0;
        settle();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 fiq after reset", 32'(fiq_o), 32'd0);
        rd(12'h00C, v); chk("R1 prio after reset", v, 32'd0);
        rd(12'h014, v); chk("R1 group after reset", v, 32'd0);
        rd(12'h404, v); chk("R1 status after reset", v, 32'd0);
        rd(12'h200, v); chk("R1 enable after reset", v, 32'd0);
    endtask

    task automatic t_pulse();
        logic [31:0] v;
        wr(12'h200, 32'h0000_0020);
        rd(12'h200, v); chk("R11 enable readback", v, 32'h20);
        pulse(5);
        rd(12'h404, v); chk("R2 pulse latched", v, 32'h20);
        chk("R8 fiq on pulse", 32'(fiq_o), 32'd1);
        rd(12'h00C, v); chk("R6 prio src5", v, 32'd6);
        rd(12'h00C, v);
        chk("R8 no mask without vector read", 32'(fiq_o), 32'd1);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(12'h404, 32'h0);
        rd(12'h404, v); chk("R4 zero write keeps bit", v, 32'h20);
        wr(12'h404, 32'h20);
        rd(12'h404, v); chk("R4 one write clears", v, 32'h0);
        chk("R8 fiq low after clear", 32'(fiq_o), 32'd0);
        pulse(5);
        rd(12'h404, v); chk("R4 new pulse recaptured", v, 32'h20);
        wr(12'h414, 32'h20);
        rd(12'h404, v); chk("R4 clear via fiq status reg", v, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        wr(12'h23C, 32'h100);
        rd(12'h23C, v); chk("R11 type readback", v, 32'h100);
        wr(12'h220, 32'h100);
        @(negedge clk); irq_in[40] = 1'b1;
        settle();
        rd(12'h424, v); chk("R3 level latched", v, 32'h100);
        wr(12'h434, 32'h100);
        rd(12'h424, v); chk("R3 relatch while high", v, 32'h100);
    endtask

    task automatic t_prio();
        logic [31:0] v;
        pulse(5);
        rd(12'h00C, v); chk("R6 lowest wins", v, 32'd6);
        rd(12'h014, v); chk("R7 both groups", v, 32'h3);
        wr(12'h200, 32'h0);
        rd(12'h00C, v); chk("R6 disabled skipped", v, 32'd41);
        rd(12'h014, v); chk("R7 group1 only", v, 32'h2);
        rd(12'h404, v); chk("R5 raw status", v, 32'h20);
        rd(12'h414, v); chk("R5 enabled status", v, 32'h0);
        rd(12'h100, v); chk("R11 unmapped", v, 32'h0);
        wr(12'h404, 32'h20);
        @(negedge clk); irq_in[40] = 1'b0;
        settle();
        wr(12'h424, 32'h100);
        rd(12'h00C, v); chk("R6 none pending", v, 32'd0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(12'h200, 32'h0000_040A);
        pulse(3);
        pulse(10);
        chk("R8 fiq before arming", 32'(fiq_o), 32'd1);
        rd(12'h01C, v); chk("R9 vector src3", v, 32'd4);
        chk("R9 masked fiq low", 32'(fiq_o), 32'd0);
        rd(12'h00C, v); chk("R6 prio ignores mask", v, 32'd4);
        rd(12'h01C, v); chk("R9 vector none unmasked", v, 32'd0);
        pulse(1);
        chk("R9 higher source passes mask", 32'(fiq_o), 32'd1);
        rd(12'h01C, v); chk("R9 vector src1", v, 32'd2);
        chk("R9 rearmed fiq low", 32'(fiq_o), 32'd0);
        wr(12'h404, 32'h400);
        chk("R10 other clear keeps mask", 32'(fiq_o), 32'd0);
        wr(12'h414, 32'h2);
        chk("R10 release raises fiq", 32'(fiq_o), 32'd1);
        wr(12'h404, 32'h8);
        chk("R8 fiq low all cleared", 32'(fiq_o), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pulse();
        t_w1c();
        t_level();
        t_prio();
        t_mask();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule